// File: doc/BRIEF.md
# Instruction-Embedded ROM Block Switcher

This block sits between the instruction fetch bus of a small calculator-class processor and a 16K-word ROM organised as four 4K-word blocks. The processor sees two 4K-word pages. The lower page always shows block 0. The upper page shows whichever block is currently selected. Every 16-bit word fetched through the block is inspected, and only its low 10 bits go back to the processor as the instruction.

The upper page can be remapped through the spare upper bits of the fetched word itself. There is no separate control register. A guard field must be zero. If it is, an enable bit marks the word as a switch command, and a two-bit field names the block for the upper page. Three fixed bank-enable opcode words, in their widened form, are also recognised and select blocks 1, 2 and 3. The unwidened fourth bank-enable opcode has no effect.

A switch is registered on the fetch that carries it. That word is still read from the old block. The new block is used from the next fetch on. The ROM is read asynchronously: the ROM address is combinational from the page inputs and the current block, and the returned data is expected in the same cycle.

Top module: `rom_block_switch`

## Requirements
- R1: A fetch from the lower page (`page_sel`=0) drives `rom_addr` = {2'b00, `page_addr`}, whatever block is selected for the upper page.
- R2: A fetch from the upper page (`page_sel`=1) drives `rom_addr` = {selected block, `page_addr`}. After synchronous reset the selected block is 1.
- R3: While `fetch` is high, `instr` equals `rom_data[9:0]`. While `fetch` is low, `instr` is 0.
- R4: A fetched word with bits 15:13 = 000 and bit 12 = 1 selects block `rom_data[11:10]` (00→0, 01→1, 10→2, 11→3).
- R5: The fetched words 16'h1500, 16'h1980 and 16'h1D40 select blocks 1, 2 and 3 respectively.
- R6: The fetched word 16'h01C0 leaves the selected block unchanged.
- R7: A fetched word with any of bits 15:13 set leaves the selected block unchanged, whatever bits 12:10 hold.
- R8: A fetched word with bits 15:12 = 0000 leaves the selected block unchanged.
- R9: A switch applies from the next fetch on. The word that carries it is addressed with the block that was selected before it.
- R10: Data on `rom_data` while `fetch` is low never changes the selected block.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fetch | input | 1 | Fetch strobe, one word per cycle while high |
| page_sel | input | 1 | 0 = lower page, 1 = upper page |
| page_addr | input | 12 | Word offset within the page |
| rom_data | input | 16 | Word returned by the ROM for `rom_addr` |
| rom_addr | output | 14 | ROM word address {block, offset} |
| instr | output | 10 | Instruction passed to the processor |

## Verification
The hardest case to reach from the ports is the rejection of a switch-looking word: the enable and block bits are set, but a guard bit is also set. Rejection can only be seen on a later upper-page fetch, and only if that fetch would have shown a different block. The bench therefore first places a known block in the upper page with a lower-page command. It then fetches each of the 64 combinations of bits 15:10 from the upper page and follows it with a plain upper-page fetch. The starting block differs from the block each command names, so a wrong switch, or a missing one, changes the address that is checked.

// File: rtl/romsw_pkg.sv
package romsw_pkg;

    parameter int WORD_W    = 16;
    parameter int INSTR_W   = 10;
    parameter int OFS_W     = 12;
    parameter int NUM_BLK   = 4;
    parameter int BLK_W     = $clog2(NUM_BLK);
    parameter int ADDR_W    = BLK_W + OFS_W;
    parameter int EN_BIT    = 12;
    parameter int GUARD_LSB = 13;
    parameter int SEL_LSB   = EN_BIT - BLK_W;

    typedef logic [BLK_W-1:0]   blk_t;
    typedef logic [WORD_W-1:0]  word_t;
    typedef logic [OFS_W-1:0]   ofs_t;
    typedef logic [ADDR_W-1:0]  addr_t;
    typedef logic [INSTR_W-1:0] instr_t;

    parameter blk_t RESET_BLK = blk_t'(1);

    typedef enum logic [1:0] {
        CMD_NONE   = 2'd0,
        CMD_FIELD  = 2'd1,
        CMD_BANKEN = 2'd2
    } cmd_kind_e;

    typedef struct packed {
        cmd_kind_e kind;
        blk_t      blk;
    } cmd_t;

    function automatic logic guard_clear(input word_t w);
        return w[WORD_W-1:GUARD_LSB] == '0;
    endfunction

    function automatic cmd_t field_cmd(input word_t w);
        cmd_t c;
        c.kind = CMD_NONE;
        c.blk  = '0;
        if (guard_clear(w) && w[EN_BIT]) begin
            c.kind = CMD_FIELD;
            c.blk  = w[EN_BIT-1:SEL_LSB];
        end
        return c;
    endfunction

    function automatic cmd_t banken_cmd(input word_t w);
        cmd_t c;
        c.kind = CMD_BANKEN;
        c.blk  = '0;
        case (w)
            16'h1500: c.blk = blk_t'(1);
            16'h1980: c.blk = blk_t'(2);
            16'h1D40: c.blk = blk_t'(3);
            default:  c.kind = CMD_NONE;
        endcase
        return c;
    endfunction

endpackage

// File: rtl/romsw_cmd_decode.sv
module romsw_cmd_decode
    import romsw_pkg::*;
#(
    parameter bit BANKEN_ON = 1'b1
) (
    input  word_t word_i,
    output cmd_t  cmd_o
);

    cmd_t fld_c;
    cmd_t ben_c;

    always_comb fld_c = field_cmd(word_i);

    generate
        if (BANKEN_ON) begin : g_banken
            always_comb ben_c = banken_cmd(word_i);
        end else begin : g_no_banken
            always_comb begin
                ben_c.kind = CMD_NONE;
                ben_c.blk  = '0;
            end
        end
    endgenerate

    // Bank-enable words take priority; for the supported words both agree.
    always_comb begin
        if (ben_c.kind != CMD_NONE) cmd_o = ben_c;
        else                        cmd_o = fld_c;
    end

endmodule

// File: rtl/romsw_bank_reg.sv
module romsw_bank_reg
    import romsw_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic fetch_i,
    input  cmd_t cmd_i,
    output blk_t blk_q
);

    always_ff @(posedge clk) begin
        if (rst)
            blk_q <= RESET_BLK;
        else if (fetch_i && cmd_i.kind != CMD_NONE)
            blk_q <= cmd_i.blk;
    end

endmodule

// File: rtl/romsw_addr_map.sv
module romsw_addr_map
    import romsw_pkg::*;
(
    input  logic   page_sel_i,
    input  ofs_t   ofs_i,
    input  blk_t   upper_blk_i,
    output addr_t  addr_o
);

    blk_t page_blk;

    always_comb begin
        page_blk = page_sel_i ? upper_blk_i : blk_t'(0);
        addr_o   = {page_blk, ofs_i};
    end

endmodule

// File: rtl/rom_block_switch.sv
module rom_block_switch
    import romsw_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                fetch,
    input  logic                page_sel,
    input  logic [OFS_W-1:0]    page_addr,
    input  logic [WORD_W-1:0]   rom_data,
    output logic [ADDR_W-1:0]   rom_addr,
    output logic [INSTR_W-1:0]  instr
);

    cmd_t cmd;
    blk_t upper_blk;

    romsw_cmd_decode #(.BANKEN_ON(1'b1)) dec_i (
        .word_i (rom_data),
        .cmd_o  (cmd)
    );

    romsw_bank_reg bank_i (
        .clk     (clk),
        .rst     (rst),
        .fetch_i (fetch),
        .cmd_i   (cmd),
        .blk_q   (upper_blk)
    );

    romsw_addr_map map_i (
        .page_sel_i  (page_sel),
        .ofs_i       (page_addr),
        .upper_blk_i (upper_blk),
        .addr_o      (rom_addr)
    );

    always_comb instr = fetch ? rom_data[INSTR_W-1:0] : '0;

endmodule

// File: rtl/rom_block_switch_chk.sv
module rom_block_switch_chk
    import romsw_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                fetch,
    input  logic                page_sel,
    input  logic [WORD_W-1:0]   rom_data,
    input  logic [ADDR_W-1:0]   rom_addr,
    input  logic [BLK_W-1:0]    upper_blk
);

    a_r1_lower_block0: assert property (@(posedge clk) disable iff (rst)
        fetch && !page_sel |-> rom_addr[ADDR_W-1:OFS_W] == '0);

    a_r2_upper_uses_reg: assert property (@(posedge clk) disable iff (rst)
        fetch && page_sel |-> rom_addr[ADDR_W-1:OFS_W] == upper_blk);

    a_r2_reset_block: assert property (@(posedge clk)
        rst |=> upper_blk == RESET_BLK);

    a_r4_field_select: assert property (@(posedge clk) disable iff (rst)
        fetch && rom_data[WORD_W-1:EN_BIT] == 4'b0001 |=>
            upper_blk == $past(rom_data[EN_BIT-1:SEL_LSB]));

    a_r6_fourth_ignored: assert property (@(posedge clk) disable iff (rst)
        fetch && rom_data == 16'h01C0 |=> $stable(upper_blk));

    a_r7_guard_blocks: assert property (@(posedge clk) disable iff (rst)
        fetch && rom_data[WORD_W-1:GUARD_LSB] != '0 |=> $stable(upper_blk));

    a_r8_plain_word: assert property (@(posedge clk) disable iff (rst)
        fetch && rom_data[WORD_W-1:EN_BIT] == 4'b0000 |=> $stable(upper_blk));

    a_r10_idle_hold: assert property (@(posedge clk) disable iff (rst)
        !fetch |=> $stable(upper_blk));

endmodule

bind rom_block_switch rom_block_switch_chk chk_i (
    .clk       (clk),
    .rst       (rst),
    .fetch     (fetch),
    .page_sel  (page_sel),
    .rom_data  (rom_data),
    .rom_addr  (rom_addr),
    .upper_blk (upper_blk)
);

// File: tb/rom_block_switch_tb_top.sv
`timescale 1ns/100ps
module rom_block_switch_tb_top;

    logic        clk = 1'b0;
    logic        rst;
    logic        fetch;
    logic        page_sel;
    logic [11:0] page_addr;
    logic [15:0] rom_data;
    logic [13:0] rom_addr;
    logic [9:0]  instr;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;
    logic [1:0] exp_blk;

    always #2.5 clk = ~clk;

    rom_block_switch dut_i (
        .clk       (clk),
        .rst       (rst),
        .fetch     (fetch),
        .page_sel  (page_sel),
        .page_addr (page_addr),
        .rom_data  (rom_data),
        .rom_addr  (rom_addr),
        .instr     (instr)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Bench model of the requirements: R4/R5 switch, R6/R7/R8 hold.
    function automatic logic [1:0] next_blk(input logic [1:0] cur, input logic [15:0] w);
        if (w[15:13] == 3'b000 && w[12]) return w[11:10];
        return cur;
    endfunction

    task automatic do_fetch(input logic ps, input logic [11:0] ofs,
                            input logic [15:0] w, input string tag);
        logic [13:0] ea;
        @(negedge clk);
        fetch = 1'b1; page_sel = ps; page_addr = ofs; rom_data = w;
        #1;
        ea = {(ps ? exp_blk : 2'd0), ofs};
        check(rom_addr == ea, tag, int'(rom_addr), int'(ea));
        check(instr == w[9:0], {tag, " R3 instr"}, int'(instr), int'(w[9:0]));
        exp_blk = next_blk(exp_blk, w);
    endtask

    task automatic do_idle(input logic [15:0] w);
        @(negedge clk);
        fetch = 1'b0; page_sel = 1'b1; page_addr = 12'h0; rom_data = w;
        #1;
        check(instr == 10'd0, "R3 idle instr", int'(instr), 0);
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            n_fail++; n_chk++;
            $display("FAIL watchdog expired actual=1 expected=0");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; fetch = 1'b0; page_sel = 1'b0; page_addr = '0; rom_data = '0;
        exp_blk = 2'd1;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R2: reset maps block 1 into the upper page
        do_fetch(1'b1, 12'h123, 16'h0055, "R2 reset block");

        // R1: lower page sweep under each upper block
        for (int b = 0; b < 4; b++) begin
            do_fetch(1'b0, 12'h000, 16'h1000 | 16'(b << 10), "R1 set");
            for (int k = 0; k < 16; k++)
                do_fetch(1'b0, 12'(k * 273), 16'h0200 | 16'(k), "R1 lower");
            do_fetch(1'b1, 12'hFFF, 16'h0001, "R2 upper");
        end

        // R4 R7 R8 R9: every value of bits 15:10, from a start block that differs
        for (int hi = 0; hi < 64; hi++) begin
            logic [1:0] s;
            s = 2'(hi[1:0] + 2'd2);
            do_fetch(1'b0, 12'h010, 16'h1000 | 16'(s) << 10, "R4 preset");
            do_fetch(1'b1, 12'(hi * 61), 16'(hi << 10) | 16'h02A5, "R9 old block");
            do_fetch(1'b1, 12'(hi * 37), 16'h0000, "R4 R7 R8 after");
        end

        // R5: bank-enable words
        do_fetch(1'b0, 12'h001, 16'h1980, "R5 banken2");
        do_fetch(1'b1, 12'h002, 16'h1D40, "R5 banken2 applied");
        do_fetch(1'b1, 12'h003, 16'h1500, "R5 banken3 applied");
        do_fetch(1'b1, 12'h004, 16'h0000, "R5 banken1 applied");

        // R6: the fourth bank-enable word is ignored
        do_fetch(1'b0, 12'h005, 16'h1C00, "R6 preset 3");
        do_fetch(1'b1, 12'h006, 16'h01C0, "R6 fourth");
        do_fetch(1'b1, 12'h007, 16'h0000, "R6 hold");

        // R10: switch-looking data without a fetch is ignored
        do_idle(16'h1400);
        do_idle(16'h1980);
        do_fetch(1'b1, 12'h008, 16'h0000, "R10 idle hold");

        // R9: back-to-back commands each read from the previous block
        do_fetch(1'b1, 12'h100, 16'h1000, "R9 chain a");
        do_fetch(1'b1, 12'h101, 16'h1800, "R9 chain b");
        do_fetch(1'b1, 12'h102, 16'h1C00, "R9 chain c");
        do_fetch(1'b1, 12'h103, 16'h0000, "R9 chain d");

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule